// File: doc/BRIEF.md
# SD Bus Clock Rate Controller

This block produces the card-side bus clock by dividing the system clock. The divide amount is a power of two. Its exponent is picked for a requested target rate by halving a reference rate until the result no longer exceeds the target. The reference is 24 MHz for ordinary cards and 48 MHz for cards flagged as high-capacity. Three rate requests exist: a slow 400 kHz rate for reset and card identification, a normal 24 MHz rate once identification is done, and a 48 MHz rate after a successful high-speed switch. In this model each half-period of the bus clock lasts 2^e system cycles, where e is the applied exponent.

The clock is gated by strobes. A start strobe sets the running status and begins with a full low phase. A stop strobe asks the divider to park the clock low at the next point where it is low. A controller then polls the running status in fixed tick intervals. It raises a timeout flag if the clock has not stopped within a bounded number of ticks. A stop request on a clock that is already stopped does nothing and counts as success. A new exponent only takes effect at the start of a low phase, so no shortened pulse ever appears on the bus.

Top module: `sdclk_rate_ctl`

## Requirements
- R1: After a synchronous active-low reset, `clk_run`, `bus_clk` and `stop_timeout` are 0 and `rate_exp` is 0.
- R2: The target exponent is the smallest e (capped at MAX_EXP) such that the target is not below reference/2^e. The reference is 24 MHz when `high_cap`=0 and 48 MHz when `high_cap`=1. `rate_sel` encodings: 0 = 400 kHz, 1 = 24 MHz, 2 = 48 MHz, 3 = treated as 400 kHz.
- R3: While running, every high phase and every low phase of `bus_clk` lasts exactly 2^`rate_exp` system cycles.
- R4: A change of `rate_sel` while running leaves the current high phase at its old length. The new exponent appears on `rate_exp` at the next falling edge of `bus_clk`, and `rate_exp` never changes while `bus_clk` is high.
- R5: A start strobe on a stopped clock raises `clk_run` within two system-clock cycles. The first bus phase is low and `rate_exp` equals the target exponent.
- R6: A stop strobe while `clk_run` is 0 leaves `clk_run` at 0 and leaves `stop_timeout` at 0. It also clears a previously set timeout.
- R7: A stop strobe during a low phase drops `clk_run` one cycle after the strobe is sampled, with `bus_clk` held low and no timeout.
- R8: If `clk_run` is still 1 after POLL_LIMIT ticks of TICK_CYC cycles from the stop strobe, `stop_timeout` becomes 1 exactly then. The clock still parks low at the end of its high phase, and the flag stays set until the next strobe.
- R9: When start and stop strobes arrive in the same cycle, the stop wins. A stopped clock stays stopped, and a running clock is brought to a stop.
- R10: While stopped, `bus_clk` stays 0, and changes to `rate_sel` or `high_cap` do not alter `rate_exp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Requested rate: 0 slow, 1 normal, 2 high-speed, 3 slow |
| high_cap | input | 1 | Selects the 48 MHz reference when 1 |
| start_strb | input | 1 | One-cycle request to run the bus clock |
| stop_strb | input | 1 | One-cycle request to stop the bus clock |
| bus_clk | output | 1 | Divided card-side bus clock |
| clk_run | output | 1 | Bus clock running status |
| rate_exp | output | EXP_W | Exponent currently applied by the divider |
| stop_timeout | output | 1 | Stop did not complete within the poll window |

## Verification
A wrong half-period reload or a wrong exponent shows at the ports within one bus period. The measured high or low phase length then differs from 2^e, and `rate_exp` disagrees with the arithmetic target. If the exponent update were not held back to the falling edge, the high phase in progress at a rate change would come out shortened, and this is visible in that same phase. A broken stop handshake shows in two ways: either `clk_run` fails to fall by the cycle after a low-phase stop, or `stop_timeout` rises earlier or later than exactly POLL_LIMIT*TICK_CYC cycles after a stop issued early in a long high phase.

// File: rtl/sdclk_pkg.sv
// Package: shared rate encodings and the halving rule for the divide exponent.
// Assumes rates are given in Hz as 64-bit integers.
package sdclk_pkg;

    typedef enum logic [1:0] {
        RS_SLOW = 2'd0,
        RS_NORM = 2'd1,
        RS_FAST = 2'd2,
        RS_RSVD = 2'd3
    } rate_sel_e;

    // Count halvings of ref_hz while the target stays below it, capped at max_e.
    function automatic int halving_exp(longint tgt_hz, longint ref_hz, int max_e);
        longint r;
        int     e;
        r = ref_hz;
        e = 0;
        for (int i = 0; i < max_e; i++) begin
            if (tgt_hz < r) begin
                e = e + 1;
                r = r >> 1;
            end
        end
        return e;
    endfunction

endpackage

// File: rtl/sdclk_exp_sel.sv
// Module: target exponent selector.
// Builds the exponent table for both references at elaboration time and
// picks the entry for the current rate request and capacity flag.
// Assumes all rates are static parameters.
module sdclk_exp_sel
    import sdclk_pkg::*;
#(
    parameter longint REF_NORM_HZ = 24_000_000,
    parameter longint REF_HIGH_HZ = 48_000_000,
    parameter longint SLOW_HZ     = 400_000,
    parameter longint NORM_HZ     = 24_000_000,
    parameter longint FAST_HZ     = 48_000_000,
    parameter int     MAX_EXP     = 7,
    parameter int     EXP_W       = 3
) (
    input  logic [1:0]       rate_sel,
    input  logic             high_cap,
    output logic [EXP_W-1:0] tgt_exp
);

    logic [EXP_W-1:0] e_slow [2];
    logic [EXP_W-1:0] e_norm [2];
    logic [EXP_W-1:0] e_fast [2];

    // One table column per reference: index 0 normal, index 1 high-capacity.
    for (genvar g = 0; g < 2; g++) begin : g_ref
        localparam longint REF_HZ = (g == 0) ? REF_NORM_HZ : REF_HIGH_HZ;
        assign e_slow[g] = EXP_W'(halving_exp(SLOW_HZ, REF_HZ, MAX_EXP));
        assign e_norm[g] = EXP_W'(halving_exp(NORM_HZ, REF_HZ, MAX_EXP));
        assign e_fast[g] = EXP_W'(halving_exp(FAST_HZ, REF_HZ, MAX_EXP));
    end

    // Select the entry for the requested rate; the reserved code falls back to slow.
    always_comb begin
        case (rate_sel_e'(rate_sel))
            RS_NORM: tgt_exp = e_norm[high_cap];
            RS_FAST: tgt_exp = e_fast[high_cap];
            default: tgt_exp = e_slow[high_cap];
        endcase
    end

endmodule

// File: rtl/sdclk_divider.sv
// Module: power-of-two bus clock divider with glitch-free gating.
// Each half-period lasts 2^cur_exp cycles. The exponent is reloaded only
// when the bus clock falls, and stopping parks the clock low.
// Assumes start_go and halt_req come from the stop controller.
module sdclk_divider #(
    parameter int MAX_EXP = 7,
    parameter int EXP_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] tgt_exp,
    input  logic             start_go,
    input  logic             halt_req,
    output logic             bus_clk,
    output logic             running,
    output logic [EXP_W-1:0] cur_exp
);

    localparam int HC_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [HC_W-1:0] hcnt;
    logic            park_now;

    // Half-period reload value: 2^e - 1 as a mask of e ones.
    function automatic logic [HC_W-1:0] half_of(logic [EXP_W-1:0] e);
        return ~({HC_W{1'b1}} << e);
    endfunction

    // Stop is allowed while low, or at the last cycle of a high phase.
    assign park_now = halt_req && !start_go && (!bus_clk || (hcnt == '0));

    // Divider state: start, park, toggle with exponent reload on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            bus_clk <= 1'b0;
            cur_exp <= '0;
            hcnt    <= '0;
        end else if (!running) begin
            if (start_go) begin
                running <= 1'b1;
                bus_clk <= 1'b0;
                cur_exp <= tgt_exp;
                hcnt    <= half_of(tgt_exp);
            end
        end else if (park_now) begin
            running <= 1'b0;
            bus_clk <= 1'b0;
        end else if (hcnt == '0) begin
            if (bus_clk) begin
                bus_clk <= 1'b0;
                cur_exp <= tgt_exp;
                hcnt    <= half_of(tgt_exp);
            end else begin
                bus_clk <= 1'b1;
                hcnt    <= half_of(cur_exp);
            end
        end else begin
            hcnt <= hcnt - 1'b1;
        end
    end

endmodule

// File: rtl/sdclk_stop_ctl.sv
// Module: start/stop handshake with a bounded poll for the stop.
// It polls the running status once per cycle and counts ticks of TICK_CYC
// cycles. After POLL_LIMIT ticks without a stop it flags a timeout.
// Assumes strobes are single-cycle; stop has priority over start.
module sdclk_stop_ctl #(
    parameter int TICK_CYC   = 250,
    parameter int POLL_LIMIT = 1000,
    parameter int TICK_W     = 8,
    parameter int POLL_W     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_strb,
    input  logic stop_strb,
    input  logic running,
    output logic start_go,
    output logic halt_req,
    output logic timeout
);

    logic              polling;
    logic [TICK_W-1:0] tick;
    logic [POLL_W-1:0] polls;

    // A start only counts when no stop arrives in the same cycle.
    assign start_go = start_strb && !stop_strb;

    // Handshake state: latch the halt, poll the status, flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polling  <= 1'b0;
            halt_req <= 1'b0;
            timeout  <= 1'b0;
            tick     <= '0;
            polls    <= '0;
        end else if (stop_strb) begin
            timeout <= 1'b0;
            tick    <= '0;
            polls   <= '0;
            if (running) begin
                halt_req <= 1'b1;
                polling  <= 1'b1;
            end else begin
                polling  <= 1'b0;
            end
        end else if (start_strb) begin
            halt_req <= 1'b0;
            polling  <= 1'b0;
            timeout  <= 1'b0;
        end else if (polling) begin
            if (!running) begin
                polling <= 1'b0;
            end else if (tick == TICK_W'(TICK_CYC - 1)) begin
                tick <= '0;
                if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                    timeout <= 1'b1;
                    polling <= 1'b0;
                end else begin
                    polls <= polls + 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdclk_rate_ctl.sv
// Module: SD bus clock rate controller (top).
// Ties together the exponent selector, the stop handshake and the divider.
// Assumes the system clock runs at twice the reference rate, so one
// half-period of 2^e cycles matches reference/2^e.
module sdclk_rate_ctl #(
    parameter longint REF_NORM_HZ = 24_000_000,
    parameter longint REF_HIGH_HZ = 48_000_000,
    parameter longint SLOW_HZ     = 400_000,
    parameter longint NORM_HZ     = 24_000_000,
    parameter longint FAST_HZ     = 48_000_000,
    parameter int     MAX_EXP     = 7,
    parameter int     TICK_CYC    = 250,
    parameter int     POLL_LIMIT  = 1000,
    localparam int    EXP_W       = (MAX_EXP > 0) ? $clog2(MAX_EXP + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic             high_cap,
    input  logic             start_strb,
    input  logic             stop_strb,
    output logic             bus_clk,
    output logic             clk_run,
    output logic [EXP_W-1:0] rate_exp,
    output logic             stop_timeout
);

    localparam int TICK_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    logic [EXP_W-1:0] tgt_exp;
    logic             start_go;
    logic             halt_req;

    sdclk_exp_sel #(
        .REF_NORM_HZ (REF_NORM_HZ),
        .REF_HIGH_HZ (REF_HIGH_HZ),
        .SLOW_HZ     (SLOW_HZ),
        .NORM_HZ     (NORM_HZ),
        .FAST_HZ     (FAST_HZ),
        .MAX_EXP     (MAX_EXP),
        .EXP_W       (EXP_W)
    ) u_sel (
        .rate_sel (rate_sel),
        .high_cap (high_cap),
        .tgt_exp  (tgt_exp)
    );

    sdclk_stop_ctl #(
        .TICK_CYC   (TICK_CYC),
        .POLL_LIMIT (POLL_LIMIT),
        .TICK_W     (TICK_W),
        .POLL_W     (POLL_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_strb (start_strb),
        .stop_strb  (stop_strb),
        .running    (clk_run),
        .start_go   (start_go),
        .halt_req   (halt_req),
        .timeout    (stop_timeout)
    );

    sdclk_divider #(
        .MAX_EXP (MAX_EXP),
        .EXP_W   (EXP_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_exp  (tgt_exp),
        .start_go (start_go),
        .halt_req (halt_req),
        .bus_clk  (bus_clk),
        .running  (clk_run),
        .cur_exp  (rate_exp)
    );

endmodule

// File: rtl/sdclk_rate_ctl_chk.sv
// Module: property checker for the SD bus clock rate controller.
// Watches only the top-level ports; attached to the top by bind below.
module sdclk_rate_ctl_chk #(
    parameter int EXP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_strb,
    input logic             stop_strb,
    input logic             bus_clk,
    input logic             clk_run,
    input logic [EXP_W-1:0] rate_exp,
    input logic             stop_timeout
);

    // R10
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |-> !bus_clk);

    // R4
    exp_swap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_exp) |-> !bus_clk);

    // R5
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_strb && !stop_strb && !clk_run) |=> clk_run);

    // R6
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strb && !clk_run) |=> (!clk_run && !stop_timeout));

    // R8
    timeout_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_timeout) |-> $past(clk_run));

    // R9
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_strb && stop_strb && !clk_run) |=> !clk_run);

endmodule

bind sdclk_rate_ctl sdclk_rate_ctl_chk #(.EXP_W(EXP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_strb   (start_strb),
    .stop_strb    (stop_strb),
    .bus_clk      (bus_clk),
    .clk_run      (clk_run),
    .rate_exp     (rate_exp),
    .stop_timeout (stop_timeout)
);

// File: tb/sdclk_rate_ctl_tb.sv
// Bench: sweeps every rate code and capacity flag, measures bus phases,
// and exercises the stop handshake, its timeout and strobe priority.
module sdclk_rate_ctl_tb;

    localparam int TICK  = 2;
    localparam int POLL  = 5;
    localparam int LIMIT = TICK * POLL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       high_cap = 1'b0;
    logic       start_strb = 1'b0;
    logic       stop_strb = 1'b0;
    logic       bus_clk;
    logic       clk_run;
    logic [2:0] rate_exp;
    logic       stop_timeout;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdclk_rate_ctl #(.TICK_CYC(TICK), .POLL_LIMIT(POLL)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_sel     (rate_sel),
        .high_cap     (high_cap),
        .start_strb   (start_strb),
        .stop_strb    (stop_strb),
        .bus_clk      (bus_clk),
        .clk_run      (clk_run),
        .rate_exp     (rate_exp),
        .stop_timeout (stop_timeout)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected exponent from the halving rule of R2.
    function automatic int exp_of(input int code, input bit hc);
        longint tgt;
        longint r;
        int     e;
        tgt = (code == 1) ? 64'd24_000_000 : (code == 2) ? 64'd48_000_000 : 64'd400_000;
        r   = hc ? 64'd48_000_000 : 64'd24_000_000;
        e   = 0;
        while (tgt < r && e < 7) begin
            e++;
            r = r >> 1;
        end
        return e;
    endfunction

    task automatic pulse_start();
        start_strb = 1'b1;
        @(negedge clk);
        start_strb = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_strb = 1'b1;
        @(negedge clk);
        stop_strb = 1'b0;
    endtask

    // Skip to the next full high phase, then count its high and low samples.
    task automatic measure(output int hi, output int lo);
        while (bus_clk) @(negedge clk);
        while (!bus_clk) @(negedge clk);
        hi = 0;
        while (bus_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!bus_clk) begin lo++; @(negedge clk); end
    endtask

    task automatic wait_stopped();
        int k;
        k = 0;
        while (clk_run && k < 600) begin k++; @(negedge clk); end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        int lo;
        int e;
        int prev_e;
        int bad_hi;

        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 clk_run", clk_run, 0);
        chk("R1 bus_clk", bus_clk, 0);
        chk("R1 stop_timeout", stop_timeout, 0);
        chk("R1 rate_exp", rate_exp, 0);

        // R10 rate change while stopped has no effect
        rate_sel = 2'd1;
        high_cap = 1'b1;
        step(5);
        chk("R10 rate_exp held", rate_exp, 0);
        chk("R10 bus_clk low", bus_clk, 0);

        // R2/R3/R5 sweep over all codes and both references
        prev_e = 0;
        for (int code = 0; code < 4; code++) begin
            for (int hc = 0; hc < 2; hc++) begin
                rate_sel = 2'(code);
                high_cap = 1'(hc);
                step(2);
                chk("R10 rate_exp held while stopped", rate_exp, prev_e);
                e = exp_of(code, 1'(hc));
                pulse_start();
                chk("R5 first phase low", bus_clk, 0);
                step(1);
                chk("R5 clk_run within two", clk_run, 1);
                chk("R2 rate_exp", rate_exp, e);
                measure(hi, lo);
                chk("R3 high length", hi, 1 << e);
                chk("R3 low length", lo, 1 << e);
                pulse_stop();
                wait_stopped();
                chk("R7 stopped", clk_run, 0);
                chk("R7 parked low", bus_clk, 0);
                prev_e = e;
            end
        end

        // R7 stop during a low phase
        rate_sel = 2'd0;
        high_cap = 1'b0;
        pulse_start();
        while (!bus_clk) @(negedge clk);
        while (bus_clk) @(negedge clk);
        pulse_stop();
        step(1);
        chk("R7 clk_run one cycle after", clk_run, 0);
        chk("R7 bus_clk low", bus_clk, 0);
        step(LIMIT + 2);
        chk("R7 no timeout", stop_timeout, 0);

        // R8 stop early in a long high phase
        pulse_start();
        while (!bus_clk) @(negedge clk);
        pulse_stop();
        step(LIMIT - 2);
        chk("R8 timeout not yet", stop_timeout, 0);
        step(3);
        chk("R8 timeout raised", stop_timeout, 1);
        chk("R8 still running", clk_run, 1);
        while (clk_run) @(negedge clk);
        chk("R8 parked low", bus_clk, 0);
        chk("R8 flag held", stop_timeout, 1);
        pulse_stop();
        step(1);
        chk("R6 idle stop clears flag", stop_timeout, 0);
        chk("R6 idle stop keeps stopped", clk_run, 0);

        // R9 simultaneous strobes
        start_strb = 1'b1;
        stop_strb  = 1'b1;
        @(negedge clk);
        start_strb = 1'b0;
        stop_strb  = 1'b0;
        step(2);
        chk("R9 stopped stays stopped", clk_run, 0);
        pulse_start();
        step(3);
        start_strb = 1'b1;
        stop_strb  = 1'b1;
        @(negedge clk);
        start_strb = 1'b0;
        stop_strb  = 1'b0;
        wait_stopped();
        chk("R9 running is stopped", clk_run, 0);

        // R4 change of rate while running: slow (e=6) to normal (e=0)
        rate_sel = 2'd0;
        high_cap = 1'b0;
        pulse_start();
        while (!bus_clk) @(negedge clk);
        rate_sel = 2'd1;
        hi = 0;
        bad_hi = 0;
        while (bus_clk) begin
            hi++;
            if (rate_exp != 3'd6) bad_hi++;
            @(negedge clk);
        end
        chk("R4 high phase keeps old length", hi, 64);
        chk("R4 exponent steady while high", bad_hi, 0);
        chk("R4 new exponent at fall", rate_exp, 0);
        lo = 0;
        while (!bus_clk) begin lo++; @(negedge clk); end
        chk("R4 low phase new length", lo, 1);

        // R4 normal back to slow
        rate_sel = 2'd0;
        measure(hi, lo);
        chk("R4 slow high length", hi, 64);
        chk("R4 slow low length", lo, 64);
        chk("R4 slow exponent", rate_exp, 6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule